// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects interrupt request lines from up to 48 peripherals and presents a single vectored request to a processor core. Software programs a per-source enable bit and a per-source 3-bit priority through a small word-addressed register port. Every cycle the controller picks the most urgent pending, enabled source. It reports that source's exception number and priority. It raises the request to the core only when the core's global unmask is set and the candidate is more urgent than the handler now running.

The core signals that it has taken the request with a one-cycle take strobe. The controller then pushes the taken priority onto an eight-entry nesting stack. A one-cycle handler-done strobe pops that stack. The top of the stack is the running priority, which gates further preemption. Peripherals acknowledge by dropping their own request line, and the arbitration follows the request lines in the same cycle.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every enable bit and every priority is zero, the nesting stack is empty (`run_active` low), `irq_req` is low, and every register word reads zero.
- R2: Enable word address 0 holds IRQ 0..31 in bits 0..31. Word address 1 holds IRQ 32..47 in bits 0..15, and its bits 31..16 read zero.
- R3: Priority word at address 8+k holds IRQ 4k+n in bits 8n+7..8n+5, for n = 0..3. The low five bits of each byte read zero, and writes to them are ignored.
- R4: A source whose enable bit is zero never wins, whatever its request line does.
- R5: Among pending enabled sources, the lowest priority value wins, and on equal values the lower IRQ number wins. `irq_exc_num` is the winning IRQ number plus 16 and `irq_prio` is its priority. Both read zero when `irq_req` is low.
- R6: `irq_req` stays low while `irq_unmask` is low, and a take strobe given then has no effect.
- R7: While a handler runs, `irq_req` rises only for a candidate whose priority value is strictly lower than `run_prio`. An equal or lower-urgency request waits.
- R8: A take strobe while `irq_req` is high pushes `irq_prio` onto the stack, and `run_prio` becomes that value on the next cycle. A done strobe pops one entry. Popping the last entry clears `run_active`, and a done strobe on an empty stack is ignored.
- R9: The stack holds 8 nested levels. At full depth, running priority 0 blocks every request, so no push is ever attempted on a full stack.
- R10: The candidate follows the request lines within the same cycle. When the winner's line drops, the next candidate is reported without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| src_req | input | 48 | Level request line per IRQ |
| irq_unmask | input | 1 | Core's global interrupt enable |
| core_take | input | 1 | Core has taken the presented request |
| handler_done | input | 1 | Running handler has finished |
| irq_req | output | 1 | Vectored request to the core |
| irq_exc_num | output | 6 | Exception number of the request (IRQ + 16) |
| irq_prio | output | 3 | Priority of the request |
| run_active | output | 1 | A handler is running (stack not empty) |
| run_prio | output | 3 | Priority at the top of the nesting stack |

## Verification
The request outputs are combinational on the request lines, the mask and the stored state, so the bench checks them in the same cycle it changes `src_req` or `irq_unmask`, a couple of nanoseconds after the falling edge on which it drove them. Register writes, take strobes and done strobes take effect at the next rising edge. The bench holds each strobe for one full cycle from a falling edge and checks readback, `run_prio` and the new candidate after the following falling edge. Reads are combinational on the address and are sampled just after the address is set.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int NIC_NUM_SRC   = 48;
    localparam int NIC_PRIO_W    = 3;
    localparam int NIC_ID_W      = 6;
    localparam int NIC_DEPTH     = 8;
    localparam int NIC_EXC_OFS   = 16;
    localparam int NIC_ENA_BASE  = 0;
    localparam int NIC_PRIO_BASE = 8;

    typedef struct packed {
        logic                  valid;
        logic [NIC_ID_W-1:0]   id;
        logic [NIC_PRIO_W-1:0] prio;
    } nic_cand_t;

    // True when candidate a is more urgent than candidate b.
    function automatic logic nic_beats(input nic_cand_t a, input nic_cand_t b);
        if (!a.valid)
            return 1'b0;
        if (!b.valid)
            return 1'b1;
        if (a.prio != b.prio)
            return a.prio < b.prio;
        return a.id < b.id;
    endfunction

endpackage

// File: rtl/nic_regs.sv
module nic_regs
    import nic_pkg::*;
#(
    parameter int NUM_SRC = NIC_NUM_SRC,
    parameter int ADDR_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output logic [NUM_SRC-1:0]           en_vec,
    output logic [NUM_SRC*NIC_PRIO_W-1:0] prio_flat
);
    localparam int ENA_WORDS  = (NUM_SRC + 31) / 32;
    localparam int PRIO_WORDS = (NUM_SRC + 3) / 4;
    localparam int LOW_BITS   = 8 - NIC_PRIO_W;

    logic                  en_q   [NUM_SRC];
    logic [NIC_PRIO_W-1:0] prio_q [NUM_SRC];

    logic [ENA_WORDS*32-1:0]  ena_pad;
    logic [PRIO_WORDS*32-1:0] prio_pad;
    logic [31:0]              ena_word  [ENA_WORDS];
    logic [31:0]              prio_word [PRIO_WORDS];

    // Per-source storage and write decode.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int EW = NIC_ENA_BASE + s / 32;
        localparam int EB = s % 32;
        localparam int PW = NIC_PRIO_BASE + s / 4;
        localparam int PB = (s % 4) * 8 + LOW_BITS;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[s]   <= 1'b0;
                prio_q[s] <= '0;
            end else if (reg_wr) begin
                if (reg_addr == ADDR_W'(EW))
                    en_q[s] <= reg_wdata[EB];
                if (reg_addr == ADDR_W'(PW))
                    prio_q[s] <= reg_wdata[PB +: NIC_PRIO_W];
            end
        end

        assign en_vec[s] = en_q[s];
        assign prio_flat[s*NIC_PRIO_W +: NIC_PRIO_W] = prio_q[s];
    end

    // Readback images, zero-padded beyond the implemented sources.
    for (genvar g = 0; g < ENA_WORDS * 32; g++) begin : g_ena_pad
        if (g < NUM_SRC) begin : g_live
            assign ena_pad[g] = en_q[g];
        end else begin : g_dead
            assign ena_pad[g] = 1'b0;
        end
    end

    for (genvar g = 0; g < PRIO_WORDS * 4; g++) begin : g_prio_pad
        if (g < NUM_SRC) begin : g_live
            assign prio_pad[g*8 +: 8] = {prio_q[g], {LOW_BITS{1'b0}}};
        end else begin : g_dead
            assign prio_pad[g*8 +: 8] = 8'h00;
        end
    end

    for (genvar w = 0; w < ENA_WORDS; w++) begin : g_ena_word
        assign ena_word[w] = ena_pad[w*32 +: 32];
    end

    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio_word
        assign prio_word[w] = prio_pad[w*32 +: 32];
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < ENA_WORDS; w++) begin
            if (reg_addr == ADDR_W'(NIC_ENA_BASE + w))
                reg_rdata = ena_word[w];
        end
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (reg_addr == ADDR_W'(NIC_PRIO_BASE + w))
                reg_rdata = prio_word[w];
        end
    end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = NIC_NUM_SRC
) (
    input  logic [NUM_SRC-1:0]            src_req,
    input  logic [NUM_SRC-1:0]            en_vec,
    input  logic [NUM_SRC*NIC_PRIO_W-1:0] prio_flat,
    output nic_cand_t                     winner
);
    nic_cand_t cand [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
        assign cand[s].valid = src_req[s] & en_vec[s];
        assign cand[s].id    = NIC_ID_W'(s);
        assign cand[s].prio  = prio_flat[s*NIC_PRIO_W +: NIC_PRIO_W];
    end

    // Ascending scan with strict comparison keeps the lower id on ties.
    always_comb begin
        winner = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (nic_beats(cand[s], winner))
                winner = cand[s];
        end
    end

endmodule

// File: rtl/nic_nest_stack.sv
module nic_nest_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = NIC_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic [NIC_PRIO_W-1:0]     push_prio,
    input  logic                      pop,
    output logic                      active,
    output logic [NIC_PRIO_W-1:0]     top_prio,
    output logic [$clog2(DEPTH+1)-1:0] depth
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [NIC_PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      top_idx;
    logic [IDX_W-1:0]      free_idx;

    assign top_idx  = IDX_W'(cnt_q - CNT_W'(1));
    assign free_idx = IDX_W'(cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (push && pop && cnt_q != '0) begin
            mem[top_idx] <= push_prio;
        end else if (push && cnt_q != CNT_W'(DEPTH)) begin
            mem[free_idx] <= push_prio;
            cnt_q         <= cnt_q + CNT_W'(1);
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign active   = (cnt_q != '0);
    assign top_prio = active ? mem[top_idx] : '0;
    assign depth    = cnt_q;

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC     = NIC_NUM_SRC,
    parameter int STACK_DEPTH = NIC_DEPTH,
    parameter int ADDR_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_SRC-1:0]    src_req,
    input  logic                  irq_unmask,
    input  logic                  core_take,
    input  logic                  handler_done,
    output logic                  irq_req,
    output logic [NIC_ID_W-1:0]   irq_exc_num,
    output logic [NIC_PRIO_W-1:0] irq_prio,
    output logic                  run_active,
    output logic [NIC_PRIO_W-1:0] run_prio
);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);

    logic [NUM_SRC-1:0]            en_vec;
    logic [NUM_SRC*NIC_PRIO_W-1:0] prio_flat;
    nic_cand_t                     winner;
    logic                          preempt_ok;
    logic [CNT_W-1:0]              stk_depth;

    nic_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_vec    (en_vec),
        .prio_flat (prio_flat)
    );

    nic_arbiter #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .src_req   (src_req),
        .en_vec    (en_vec),
        .prio_flat (prio_flat),
        .winner    (winner)
    );

    assign preempt_ok  = !run_active || (winner.prio < run_prio);
    assign irq_req     = irq_unmask && winner.valid && preempt_ok;
    assign irq_exc_num = irq_req ? (winner.id + NIC_ID_W'(NIC_EXC_OFS)) : '0;
    assign irq_prio    = irq_req ? winner.prio : '0;

    nic_nest_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (core_take && irq_req),
        .push_prio (irq_prio),
        .pop       (handler_done),
        .active    (run_active),
        .top_prio  (run_prio),
        .depth     (stk_depth)
    );

endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
#(
    parameter int NUM_SRC     = NIC_NUM_SRC,
    parameter int STACK_DEPTH = NIC_DEPTH
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_SRC-1:0]            src_req,
    input logic [NUM_SRC-1:0]            en_vec,
    input logic                          irq_unmask,
    input logic                          core_take,
    input logic                          handler_done,
    input logic                          irq_req,
    input logic [NIC_ID_W-1:0]           irq_exc_num,
    input logic [NIC_PRIO_W-1:0]         irq_prio,
    input logic                          run_active,
    input logic [NIC_PRIO_W-1:0]         run_prio,
    input logic [$clog2(STACK_DEPTH+1)-1:0] stk_depth
);
    logic [NIC_ID_W-1:0] chk_idx;
    logic                chk_live;

    assign chk_idx  = irq_exc_num - NIC_ID_W'(NIC_EXC_OFS);
    assign chk_live = (int'(chk_idx) < NUM_SRC) && src_req[chk_idx] && en_vec[chk_idx];

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
        !irq_unmask |-> !irq_req) else $error("mask gate");  // R6

    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> chk_live) else $error("winner not live");  // R4

    AST_EXC_OFFSET: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_exc_num >= NIC_ID_W'(NIC_EXC_OFS)) else $error("exc offset");  // R5

    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        irq_req && run_active |-> irq_prio < run_prio) else $error("preempt");  // R7

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
        core_take && irq_req && !handler_done |=> run_active && run_prio == $past(irq_prio))
        else $error("push top");  // R8

    AST_POP_LAST: assert property (@(posedge clk) disable iff (rst)
        handler_done && !core_take && stk_depth == 1 |=> !run_active) else $error("pop last");  // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        core_take && irq_req |-> stk_depth < STACK_DEPTH) else $error("overflow");  // R9

endmodule

bind nest_irq_ctrl nic_checker #(
    .NUM_SRC     (NUM_SRC),
    .STACK_DEPTH (STACK_DEPTH)
) u_nic_checker (.*);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    localparam int NSRC = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NSRC-1:0] src_req = '0;
    logic        irq_unmask = 1'b0;
    logic        core_take = 1'b0;
    logic        handler_done = 1'b0;
    logic        irq_req;
    logic [5:0]  irq_exc_num;
    logic [2:0]  irq_prio;
    logic        run_active;
    logic [2:0]  run_prio;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    int m_pr [NSRC];

    always #10 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .src_req (src_req),
        .irq_unmask (irq_unmask), .core_take (core_take), .handler_done (handler_done),
        .irq_req (irq_req), .irq_exc_num (irq_exc_num), .irq_prio (irq_prio),
        .run_active (run_active), .run_prio (run_prio)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
        #2;
    endtask

    task automatic rd_chk(input string tag, input int addr, input logic [31:0] exp);
        reg_addr = 5'(addr);
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_take();
        @(negedge clk); core_take = 1'b1;
        @(negedge clk); core_take = 1'b0;
        #2;
    endtask

    task automatic pulse_done();
        @(negedge clk); handler_done = 1'b1;
        @(negedge clk); handler_done = 1'b0;
        #2;
    endtask

    task automatic set_req(input logic [NSRC-1:0] v);
        @(negedge clk); src_req = v;
        #2;
    endtask

    // Expected winner with every source enabled, no handler running.
    task automatic exp_winner(output int id, output int pr);
        id = -1; pr = 8;
        for (int i = 0; i < NSRC; i++)
            if (src_req[i] && m_pr[i] < pr) begin id = i; pr = m_pr[i]; end
    endtask

    initial begin
        #(200000 * 20);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int id, pr;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 run_active", run_active, 0);
        chk("R1 exc", irq_exc_num, 0);
        for (int a = 0; a < 20; a++) rd_chk("R1 readback", a, 32'h0);

        // R2 / R3 field positions and masked bits
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'hFFFF_FFFF);
        for (int k = 0; k < 12; k++) wr(8 + k, 32'hFFFF_FFFF);
        rd_chk("R2 ena0", 0, 32'hFFFF_FFFF);
        rd_chk("R2 ena1 upper zero", 1, 32'h0000_FFFF);
        for (int k = 0; k < 12; k++) rd_chk("R3 prio masked", 8 + k, 32'hE0E0_E0E0);
        wr(0, 32'h0); wr(1, 32'h0);

        // R4 disabled sources ignored
        irq_unmask = 1'b1;
        set_req('1);
        chk("R4 all disabled", irq_req, 0);

        // Program sweep priorities, with garbage in the low bits (R3)
        for (int k = 0; k < 12; k++) begin
            w = '0;
            for (int n = 0; n < 4; n++) begin
                m_pr[4*k+n] = ((4*k + n) * 3 + 1) % 8;
                w |= 32'((m_pr[4*k+n] << 5) | 5'h15) << (8 * n);
            end
            wr(8 + k, w);
            w = '0;
            for (int n = 0; n < 4; n++) w |= 32'(m_pr[4*k+n] << 5) << (8 * n);
            rd_chk("R3 prio readback", 8 + k, w);
        end

        // R2 / R4 / R5: each source alone enabled while all request
        for (int i = 0; i < NSRC; i++) begin
            wr(0, (i < 32) ? (32'h1 << i) : 32'h0);
            wr(1, (i >= 32) ? (32'h1 << (i - 32)) : 32'h0);
            chk("R4 lone req", irq_req, 1);
            chk("R2 R5 exc num", irq_exc_num, i + 16);
            chk("R5 prio", irq_prio, m_pr[i]);
        end

        // R5 / R10: all enabled, retire winners one by one
        wr(0, 32'hFFFF_FFFF); wr(1, 32'h0000_FFFF);
        for (int s = 0; s < NSRC; s++) begin
            exp_winner(id, pr);
            chk("R5 R10 winner", irq_exc_num, id + 16);
            chk("R5 winner prio", irq_prio, pr);
            src_req[id] = 1'b0;
            #2;
        end
        chk("R10 none left", irq_req, 0);

        // R6 mask
        irq_unmask = 1'b0;
        set_req(48'h1);
        chk("R6 masked", irq_req, 0);
        pulse_take();
        chk("R6 take ignored", run_active, 0);
        irq_unmask = 1'b1;
        #2;
        chk("R6 unmasked", irq_req, 1);

        // Nesting setup: IRQ i in 0..7 gets priority 7-i
        wr(8, 32'h80A0_C0E0);
        wr(9, 32'h0020_4060);
        for (int l = 0; l < 8; l++) begin
            set_req(48'h1 << l);
            chk("R7 preempts", irq_req, 1);
            chk("R7 exc", irq_exc_num, l + 16);
            pulse_take();
            chk("R8 run prio", run_prio, 7 - l);
            chk("R7 equal waits", irq_req, 0);
            if (l > 0) begin
                set_req(48'h1 << (l - 1));
                chk("R7 lower waits", irq_req, 0);
            end
            set_req('0);
        end
        set_req(48'hFF);
        chk("R9 full depth blocks", irq_req, 0);
        set_req('0);
        for (int l = 7; l >= 1; l--) begin
            pulse_done();
            chk("R8 pop prio", run_prio, 8 - l);
        end
        pulse_done();
        chk("R8 empty", run_active, 0);
        pulse_done();
        chk("R8 pop on empty", run_active, 0);
        set_req(48'h8);
        chk("R8 after empty pop", irq_req, 1);
        pulse_take();
        chk("R8 push after empty", run_prio, 4);
        chk("R8 active", run_active, 1);
        pulse_done();
        chk("R8 final pop", run_active, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule